// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block is the clocked front end of a single-cycle-access burst SRAM that holds its own small storage array. On every rising clock edge it samples the address, three chip enables, two address strobes, the advance input and the write controls. It decides whether a new access starts, a burst steps forward, the device drops out of selection, or nothing happens.

A new access captures the full address and seeds a 2-bit burst counter from the low two address bits. The advance input then steps that counter through four words, wrapping inside the same aligned group. Writes go in per 9-bit lane under a global-write override or a byte-enable qualified lane mask. Read data is registered and leaves through an output-enable gate. That gate stays closed for the first read cycle after the device was deselected.

The host side drives the strobes the way a processor or cache controller would. It uses the processor strobe for read bursts and the controller strobe for accesses that may write. It keeps the output enable low whenever it wants read data on `rdata`.

Top module: `sync_burst_sram`

## Requirements
- R1: The device counts as selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on the same edge. An accepted strobe on an edge where it is not selected ends any burst and clears read-valid, so `rdata_oe` goes low. Later edges with `adv_n`=0 then cause no access.
- R2: On an edge where `adsp_n`=0 and the device is selected, the whole address is captured, the counter is loaded from `addr[1:0]`, and that word is read.
- R3: When `adsp_n`=0 and `adsc_n`=0 on the same edge with `ce1_n`=0, only the processor strobe is acted on. A processor-strobe start is always a read, and the write controls on that edge have no effect on the array.
- R4: While `ce1_n`=1 the processor strobe is ignored. With `adsc_n`=1 the edge is a hold, so the current burst address and output data stay as they were.
- R5: With no strobe accepted, `adv_n`=0 and a burst open, the counter steps by one modulo 4 (2→3→0→1). `addr` bits above bit 1 stay fixed, and the access uses the stepped address.
- R6: With no strobe accepted and `adv_n`=1, no access takes place: address, counter, array and `rdata` are unchanged.
- R7: On a controller-strobe start or a burst step, `gw_n`=0 writes all four 9-bit lanes of `wdata` (lane i is bits 9i+8..9i), whatever `bwe_n` and `bw_n` show.
- R8: With `gw_n`=1 and `bwe_n`=0, each lane i with `bw_n[i]`=0 is written. When no lane is enabled, including every case with `bwe_n`=1, the access is a read.
- R9: A read access loads the addressed word into the output register on the same edge, so it is visible on `rdata` right after that edge.
- R10: `rdata_oe` is 1 only when `oe_n`=0 (asynchronously), the last access was a read and the output is not masked. Read-valid is cleared by a write access, a deselect or reset. `rdata` is all zero whenever `rdata_oe` is 0.
- R11: The first read cycle after a deselect or after reset keeps `rdata_oe` at 0. The following cycle opens the gate with the same data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low, read-only start |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Gated registered read data |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The properties assume that control inputs are stable around each rising edge and that `oe_n` is a clean level. The deselect and mask properties also assume the host never reads a word it has not written. If it did, unknown array contents could reach `rdata`. The directed bench changes every input only on the falling edge, writes each word before it reads it, and holds the chip enables at the selected levels except where a deselect or a gated processor strobe is the point of the test.

// File: rtl/sbs_pkg.sv
// Shared types for the synchronous burst SRAM controller.
// Assumes: burst length of four words, counter in the low two address bits.
package sbs_pkg;

    // What one clock edge does to the access state.
    typedef enum logic [2:0] {
        OP_HOLD,    // nothing sampled that starts or steps an access
        OP_DESEL,   // strobe seen while the device is not selected
        OP_LOAD_P,  // processor-strobe start (read only)
        OP_LOAD_C,  // controller-strobe start (read or write)
        OP_STEP     // burst advance
    } sbs_op_e;

    // Linear wrap of the 2-bit burst counter.
    function automatic logic [1:0] sbs_next_beat(input logic [1:0] beat);
        return beat + 2'd1;
    endfunction

endpackage

// File: rtl/sbs_addr_ctl.sv
// Address path: strobe priority, chip-select qualification, address capture
// and the 2-bit burst counter.
// Assumes: ADDR_W > 2; the counter only ever changes address bits [1:0].
module sbs_addr_ctl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    output sbs_op_e           op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        beat,
    output logic              open_burst
);

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] base_q;
    logic [1:0]      beat_q;
    logic            open_q;
    logic            selected;
    logic            p_taken;

    // Decode this edge's operation with the processor strobe first.
    always_comb begin
        selected = !ce1_n && ce2 && !ce3_n;
        p_taken  = !adsp_n && !ce1_n;
        if (p_taken)
            op = selected ? OP_LOAD_P : OP_DESEL;
        else if (!adsc_n)
            op = selected ? OP_LOAD_C : OP_DESEL;
        else if (!adv_n && open_q)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end

    // Address used by the array on this edge.
    always_comb begin
        case (op)
            OP_LOAD_P, OP_LOAD_C: acc_addr = addr;
            OP_STEP:              acc_addr = {base_q, sbs_next_beat(beat_q)};
            default:              acc_addr = {base_q, beat_q};
        endcase
    end

    // Capture base and counter, and track whether a burst is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= 2'd0;
            open_q <= 1'b0;
        end else begin
            case (op)
                OP_LOAD_P, OP_LOAD_C: begin
                    base_q <= addr[ADDR_W-1:2];
                    beat_q <= addr[1:0];
                    open_q <= 1'b1;
                end
                OP_STEP:  beat_q <= sbs_next_beat(beat_q);
                OP_DESEL: open_q <= 1'b0;
                default:  ;
            endcase
        end
    end

    assign cur_addr   = {base_q, beat_q};
    assign beat       = beat_q;
    assign open_burst = open_q;

endmodule

// File: rtl/sbs_lane_dec.sv
// Lane write decode: global write overrides, else byte-enable qualified selects.
// Assumes: all selects are active low; 'allow' already excludes non-write edges.
module sbs_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             allow,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);

    // Pick the lane mask for this edge.
    always_comb begin
        if (!allow)
            lane_we = '0;
        else if (!gw_n)
            lane_we = '1;
        else if (!bwe_n)
            lane_we = ~bw_n;
        else
            lane_we = '0;
    end

endmodule

// File: rtl/sbs_array.sv
// Storage: one bank per lane, lane writes and a registered read word.
// Assumes: rd_en and any lane_we bit are never high together.
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    rd_en,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] q
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] q_lane;

        // Write this lane when its enable is set.
        always_ff @(posedge clk) begin
            if (lane_we[g])
                bank[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Register this lane's read data on a read access.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_lane <= '0;
            else if (rd_en)
                q_lane <= bank[addr];
        end

        assign q[g*LANE_W +: LANE_W] = q_lane;
    end

endmodule

// File: rtl/sync_burst_sram.sv
// Top: ties address path, lane decode and array together and gates read data
// with the output enable, masking the first read after a deselect.
// Assumes: oe_n is asynchronous; everything else is sampled on the rising edge.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);

    localparam int DATA_W = LANES * LANE_W;

    sbs_op_e           op;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        beat;
    logic              open_burst;
    logic              acc;
    logic              wr_allow;
    logic              rd_acc;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] q;
    logic              rvalid_q;
    logic              mask_q;
    logic              desel_q;

    sbs_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .ce1_n      (ce1_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .adsp_n     (adsp_n),
        .adsc_n     (adsc_n),
        .adv_n      (adv_n),
        .op         (op),
        .acc_addr   (acc_addr),
        .cur_addr   (cur_addr),
        .beat       (beat),
        .open_burst (open_burst)
    );

    // Classify the edge: access, and whether writes may happen on it.
    always_comb begin
        acc      = (op == OP_LOAD_P) || (op == OP_LOAD_C) || (op == OP_STEP);
        wr_allow = (op == OP_LOAD_C) || (op == OP_STEP);
        rd_acc   = acc && (lane_we == '0);
    end

    sbs_lane_dec #(.LANES(LANES)) u_dec (
        .allow   (wr_allow),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (acc_addr),
        .rd_en   (rd_acc),
        .lane_we (lane_we),
        .wdata   (wdata),
        .q       (q)
    );

    // Track read-valid, the first-read mask and the deselected state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            mask_q   <= 1'b0;
            desel_q  <= 1'b1;
        end else begin
            mask_q <= rd_acc && desel_q;
            if (op == OP_DESEL) begin
                rvalid_q <= 1'b0;
                desel_q  <= 1'b1;
            end else if (acc) begin
                rvalid_q <= rd_acc;
                desel_q  <= 1'b0;
            end
        end
    end

    // Output gate: asynchronous enable over the registered data.
    always_comb begin
        rdata_oe = !oe_n && rvalid_q && !mask_q;
        rdata    = rdata_oe ? q : '0;
    end

endmodule

// File: rtl/sbs_chk.sv
// Property checker for sync_burst_sram, attached by bind below.
// Assumes: inputs settle before each rising edge.
module sbs_chk #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [1:0]        beat,
    input logic              open_burst,
    input logic [LANES-1:0]  lane_we,
    input logic              rd_acc,
    input logic              desel_q
);

    logic sel_in;
    logic strobe_in;
    assign sel_in    = !ce1_n && ce2 && !ce3_n;
    assign strobe_in = (!adsp_n && !ce1_n) || !adsc_n;

    assert_deselect_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_in && !sel_in) |=> !rdata_oe);

    assert_adsp_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && sel_in) |=> (cur_addr == $past(addr)));

    assert_adsp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n) |-> (lane_we == '0));

    assert_adsp_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && adsc_n) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

    assert_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_in && !adv_n && open_burst) |=> (beat == $past(beat) + 2'd1));

    assert_hold_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_in && adv_n) |=> $stable(cur_addr));

    assert_global_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n && !adsc_n && (adsp_n || ce1_n) && sel_in) |-> (&lane_we));

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe);

    assert_zero_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

    assert_first_read_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && desel_q) |=> !rdata_oe);

endmodule

bind sync_burst_sram sbs_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .DATA_W (LANES * LANE_W)
) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .adsp_n     (adsp_n),
    .adsc_n     (adsc_n),
    .adv_n      (adv_n),
    .gw_n       (gw_n),
    .oe_n       (oe_n),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe),
    .cur_addr   (cur_addr),
    .beat       (beat),
    .open_burst (open_burst),
    .lane_we    (lane_we),
    .rd_acc     (rd_acc),
    .desel_q    (desel_q)
);

// File: tb/sync_burst_sram_test.sv
// Directed bench: one task per scenario, each checking its own results.
module sync_burst_sram_test;

    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int vectors = 0;
    int miscompares = 0;

    sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; oe_n = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_c(input logic [AW-1:0] a, input logic [DW-1:0] d);
        quiet(); adsc_n = 1'b0; addr = a; gw_n = 1'b0; wdata = d;
        step(); quiet();
    endtask

    task automatic read_c(input logic [AW-1:0] a);
        quiet(); adsc_n = 1'b0; addr = a;
        step(); quiet();
    endtask

    function automatic logic [DW-1:0] lane_mask(input logic [NL-1:0] en);
        logic [DW-1:0] m = '0;
        for (int i = 0; i < NL; i++)
            if (en[i]) m[i*LW +: LW] = '1;
        return m;
    endfunction

    task automatic t_reset();
        check("R10 reset oe", DW'(rdata_oe), DW'(0));
        check("R10 reset data", rdata, '0);
    endtask

    task automatic t_global();
        write_c(8'h10, 36'hA_1B2C_3D4E);
        check("R10 write clears valid", DW'(rdata_oe), DW'(0));
        read_c(8'h10);
        check("R7 R9 global write readback", rdata, 36'hA_1B2C_3D4E);
        oe_n = 1'b1; #1;
        check("R10 oe high gates", DW'(rdata_oe), DW'(0));
        check("R10 gated data zero", rdata, '0);
        oe_n = 1'b0; #1;
    endtask

    task automatic t_mask();
        quiet(); ce2 = 1'b0; adsc_n = 1'b0; step(); quiet();
        check("R1 deselect closes", DW'(rdata_oe), DW'(0));
        adv_n = 1'b0; step(); quiet();
        check("R1 no step after deselect", DW'(rdata_oe), DW'(0));
        read_c(8'h10);
        check("R11 first read masked", DW'(rdata_oe), DW'(0));
        step();
        check("R11 R6 gate opens next cycle", rdata, 36'hA_1B2C_3D4E);
    endtask

    task automatic t_bytes();
        logic [DW-1:0] base = 36'h1_2345_6789;
        logic [DW-1:0] over = 36'hF_EDCB_A987;
        logic [DW-1:0] m    = lane_mask(4'b0101);
        write_c(8'h20, base);
        quiet(); adsc_n = 1'b0; addr = 8'h20; bwe_n = 1'b0; bw_n = 4'b1010; wdata = over;
        step(); quiet();
        quiet(); adsc_n = 1'b0; addr = 8'h20; bwe_n = 1'b1; bw_n = 4'b0000; wdata = '1;
        step(); quiet();
        check("R8 lanes 0 and 2 written, bwe high reads", rdata, (base & ~m) | (over & m));
        read_c(8'h20);
        check("R8 no write with bwe high", rdata, (base & ~m) | (over & m));
    endtask

    task automatic t_burst();
        logic [DW-1:0] d [4];
        for (int i = 0; i < 4; i++) d[i] = DW'(36'h3_0000_0000 + i * 36'h1_1111);
        write_c(8'h32, d[0]);
        for (int i = 1; i < 4; i++) begin
            quiet(); adv_n = 1'b0; gw_n = 1'b0; wdata = d[i]; step();
        end
        quiet(); adsp_n = 1'b0; addr = 8'h32; gw_n = 1'b0; wdata = '0; step(); quiet();
        check("R2 adsp start reads base", rdata, d[0]);
        adv_n = 1'b0; step(); quiet();
        check("R5 beat 2 to 3", rdata, d[1]);
        step();
        check("R6 hold keeps data", rdata, d[1]);
        adv_n = 1'b0; step();
        check("R5 wrap to beat 0", rdata, d[2]);
        step();
        check("R5 beat 1", rdata, d[3]);
        step(); quiet();
        check("R5 back to beat 2", rdata, d[0]);
    endtask

    task automatic t_priority();
        write_c(8'h40, 36'h4_4444_4444);
        quiet(); adsp_n = 1'b0; adsc_n = 1'b0; addr = 8'h40; gw_n = 1'b0; wdata = 36'hE_EEEE_EEEE;
        step(); quiet();
        check("R3 both strobes read", rdata, 36'h4_4444_4444);
        read_c(8'h40);
        check("R3 no write on processor start", rdata, 36'h4_4444_4444);
    endtask

    task automatic t_ignore();
        write_c(8'h11, 36'h5_5555_5555);
        read_c(8'h10);
        check("R4 setup read", rdata, 36'hA_1B2C_3D4E);
        quiet(); ce1_n = 1'b1; adsp_n = 1'b0; addr = 8'h20; step(); quiet();
        check("R4 adsp ignored, data held", rdata, 36'hA_1B2C_3D4E);
        adv_n = 1'b0; step(); quiet();
        check("R4 burst continues from old address", rdata, 36'h5_5555_5555);
    endtask

    initial begin : watchdog
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global();
        t_mask();
        t_bytes();
        t_burst();
        t_priority();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule